// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Datapath

This block executes a small 32-bit load/store instruction subset: register-register arithmetic, word load, word store and branch-on-equal. Each step of an instruction takes one clock. A single arithmetic unit and a single memory port are reused from step to step, so instructions of different kinds take different numbers of cycles. Holding registers carry values between steps: the program counter, the instruction register, the memory data register, the two operand registers and the result register.

A small sequencer walks each instruction through fetch and decode, then through execute, memory and write-back steps as needed. It drives the operand selects, the address select and the write strobes of the datapath through a compact strobe bundle. The memory sits outside the block: it returns read data combinationally for the byte address the block presents, decodes that address by its bits [31:2], and takes a write on the clock edge when the write enable is high.

Top module: `mcp_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0 and puts the sequencer in the fetch step; while reset is high and in the first cycle after it, the memory address is 0 and the write enable is low.
- R2: In the fetch step the memory address is the program counter, and the program counter advances by 4 through the shared arithmetic unit, so that sequential instructions are fetched from consecutive words.
- R3: Fetch and decode take one cycle each for every instruction; a register-register instruction takes 4 cycles in all, a load 5, a store 4 and a branch 3.
- R4: An instruction with bits [31:26] equal to 0 is register-register: operands come from the registers named by bits [25:21] and [20:16], the result goes to the register named by bits [15:11], and bits [5:0] select the operation: 0x20 add, 0x22 subtract, 0x24 bitwise AND, 0x25 bitwise OR, 0x2A signed set-less-than (1 or 0).
- R5: A load (bits [31:26] = 0x23) reads the word at the register named by bits [25:21] plus the sign-extended 16-bit immediate in bits [15:0], presents that address on the memory port in its fourth cycle, and writes the word into the register named by bits [20:16].
- R6: A store (bits [31:26] = 0x2B) drives the register named by bits [20:16] onto the write data and raises the write enable for exactly one cycle, the fourth of the instruction, at the address formed as for a load.
- R7: A branch (bits [31:26] = 0x04) compares the registers named by bits [25:21] and [20:16]; when equal, the next instruction comes from the address of the branch plus 4 plus the sign-extended immediate shifted left by 2 (negative offsets included); otherwise execution continues with the next word.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: The instruction register keeps the fetched word until the instruction completes, even while the memory returns data words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| memRdata | input | 32 | Word returned by memory for the current address |
| memAddr | output | 32 | Byte address: program counter during fetch, result register during data access |
| memWdata | output | 32 | Store data taken from the second operand register |
| memWe | output | 1 | Memory write strobe, high for one cycle per store |

## Verification
The assertions assume that the memory answers reads in the same cycle and that every instruction word carries one of the four supported major codes, with word-aligned load and store addresses. The stimulus is a fixed program placed in a bench memory that honours these rules: all offsets and base values keep data addresses on word boundaries, and the program ends in a branch to itself so the sequencer never runs off into unwritten words. Reset is applied both at start and in the middle of that closing loop.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  localparam int XLEN    = 32;
  localparam int NREGS   = 32;
  localparam int RIDX_W  = $clog2(NREGS);
  localparam int IMM_W   = 16;

  localparam logic [5:0] OP_ALU   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDMEM, S_LDWB, S_STMEM, S_EXEC, S_EXWB, S_BRANCH
  } stepE;

  typedef enum logic [1:0] {
    SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMMSH
  } srcBE;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } aluOpE;

  typedef struct packed {
    logic  addrFromRes;
    logic  memWe;
    logic  irWrite;
    logic  pcStep;
    logic  pcBranch;
    logic  srcAFromReg;
    srcBE  srcB;
    aluOpE aluOp;
    logic  regWrite;
    logic  dstIsRd;
    logic  wbFromMem;
  } ctlS;

endpackage

// File: rtl/mcp_alu.sv
module mcp_alu
  import mcp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOpE        op,
  output logic [W-1:0] result,
  output logic         isZero
);

  logic [W-1:0] diff;
  assign diff = opA - opB;

  always_comb begin
    unique case (op)
      ALU_SUB: result = diff;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile
  import mcp_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREGS,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wIdx,
  input  logic [W-1:0]  wData,
  input  logic [AW-1:0] rIdxA,
  input  logic [AW-1:0] rIdxB,
  output logic [W-1:0]  rDataA,
  output logic [W-1:0]  rDataB
);

  logic [W-1:0] cells [1:N-1];

  for (genvar g = 1; g < N; g++) begin : gCell
    always_ff @(posedge clk) begin
      if (we && wIdx == AW'(g)) cells[g] <= wData;
    end
  end

  assign rDataA = (rIdxA == '0) ? '0 : cells[rIdxA];
  assign rDataB = (rIdxB == '0) ? '0 : cells[rIdxB];

endmodule

// File: rtl/mcp_datapath.sv
module mcp_datapath
  import mcp_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREGS,
  localparam int AW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  ctlS          ctl,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic [5:0]   irOp,
  output logic [5:0]   irFunct
);

  logic [W-1:0] pc, ir, mdr, regA, regB, resReg;
  logic [W-1:0] rfA, rfB, opA, opB, aluY, immSx, wbData;
  logic         aluZero;
  logic [AW-1:0] rsIdx, rtIdx, rdIdx, wIdx;

  assign irOp    = ir[31:26];
  assign irFunct = ir[5:0];
  assign rsIdx   = ir[21 +: AW];
  assign rtIdx   = ir[16 +: AW];
  assign rdIdx   = ir[11 +: AW];
  assign immSx   = {{(W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

  assign opA = ctl.srcAFromReg ? regA : pc;

  always_comb begin
    unique case (ctl.srcB)
      SRCB_REG:   opB = regB;
      SRCB_FOUR:  opB = W'(4);
      SRCB_IMM:   opB = immSx;
      default:    opB = immSx << 2;
    endcase
  end

  mcp_alu #(.W(W)) i_alu (
    .opA(opA), .opB(opB), .op(ctl.aluOp), .result(aluY), .isZero(aluZero)
  );

  assign wIdx   = ctl.dstIsRd ? rdIdx : rtIdx;
  assign wbData = ctl.wbFromMem ? mdr : resReg;

  mcp_regfile #(.W(W), .N(N)) i_regfile (
    .clk(clk), .we(ctl.regWrite), .wIdx(wIdx), .wData(wbData),
    .rIdxA(rsIdx), .rIdxB(rtIdx), .rDataA(rfA), .rDataB(rfB)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      regA   <= '0;
      regB   <= '0;
      resReg <= '0;
    end else begin
      if (ctl.pcStep) pc <= aluY;
      else if (ctl.pcBranch && aluZero) pc <= resReg;
      if (ctl.irWrite) ir <= memRdata;
      mdr    <= memRdata;
      regA   <= rfA;
      regB   <= rfB;
      resReg <= aluY;
    end
  end

  assign memAddr  = ctl.addrFromRes ? resReg : pc;
  assign memWdata = regB;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.irWrite |=> pc == $past(pc) + W'(4)); // R2

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R7

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.irWrite |=> $stable(ir)); // R9

endmodule

// File: rtl/mcp_control.sv
module mcp_control
  import mcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] irOp,
  input  logic [5:0] irFunct,
  output ctlS        ctl
);

  stepE step, stepNext;
  aluOpE functOp;

  always_ff @(posedge clk) begin
    if (rst) step <= S_FETCH;
    else     step <= stepNext;
  end

  always_comb begin
    unique case (irFunct)
      FN_SUB:  functOp = ALU_SUB;
      FN_AND:  functOp = ALU_AND;
      FN_OR:   functOp = ALU_OR;
      FN_SLT:  functOp = ALU_SLT;
      default: functOp = ALU_ADD;
    endcase
  end

  always_comb begin
    stepNext = S_FETCH;
    unique case (step)
      S_FETCH:  stepNext = S_DECODE;
      S_DECODE: begin
        unique case (irOp)
          OP_ALU:   stepNext = S_EXEC;
          OP_LOAD:  stepNext = S_ADDR;
          OP_STORE: stepNext = S_ADDR;
          OP_BEQ:   stepNext = S_BRANCH;
          default:  stepNext = S_FETCH;
        endcase
      end
      S_ADDR:   stepNext = (irOp == OP_LOAD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  stepNext = S_LDWB;
      S_EXEC:   stepNext = S_EXWB;
      default:  stepNext = S_FETCH;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (step)
      S_FETCH: begin
        ctl.irWrite = 1'b1;
        ctl.pcStep  = 1'b1;
        ctl.srcB    = SRCB_FOUR;
      end
      S_DECODE: ctl.srcB = SRCB_IMMSH;
      S_ADDR: begin
        ctl.srcAFromReg = 1'b1;
        ctl.srcB        = SRCB_IMM;
      end
      S_LDMEM: ctl.addrFromRes = 1'b1;
      S_LDWB: begin
        ctl.regWrite  = 1'b1;
        ctl.wbFromMem = 1'b1;
      end
      S_STMEM: begin
        ctl.addrFromRes = 1'b1;
        ctl.memWe       = 1'b1;
      end
      S_EXEC: begin
        ctl.srcAFromReg = 1'b1;
        ctl.aluOp       = functOp;
      end
      S_EXWB: begin
        ctl.regWrite = 1'b1;
        ctl.dstIsRd  = 1'b1;
      end
      S_BRANCH: begin
        ctl.srcAFromReg = 1'b1;
        ctl.aluOp       = ALU_SUB;
        ctl.pcBranch    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> step == S_FETCH); // R1

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ctl.memWe |=> !ctl.memWe); // R6

endmodule

// File: rtl/mcp_core.sv
module mcp_core
  import mcp_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREGS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] memRdata,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWdata,
  output logic         memWe
);

  ctlS        ctl;
  logic [5:0] irOp, irFunct;

  mcp_control i_control (
    .clk(clk), .rst(rst), .irOp(irOp), .irFunct(irFunct), .ctl(ctl)
  );

  mcp_datapath #(.W(W), .N(N)) i_datapath (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .irOp(irOp), .irFunct(irFunct)
  );

  assign memWe = ctl.memWe;

endmodule

// File: tb/test_mcp_core.sv
module test_mcp_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memRdata, memAddr, memWdata;
  logic        memWe;

  logic [31:0] mem [64];
  int          cyc;
  int          nChk = 0, nFail = 0;
  bit          done = 1'b0;
  bit          logEn = 1'b1;
  int          nWr = 0;
  logic [31:0] logCyc [16], logAdr [16], logDat [16];

  localparam int N_WR = 9;
  // expected stores: cycle, byte address, data
  localparam logic [31:0] WR_CYC [N_WR] = '{37, 41, 45, 49, 53, 57, 64, 75, 89};
  localparam logic [31:0] WR_ADR [N_WR] = '{32'h90, 32'h94, 32'h98, 32'h9c, 32'ha0,
                                            32'ha4, 32'ha8, 32'hb0, 32'hb4};
  localparam logic [31:0] WR_DAT [N_WR] = '{32'd12, 32'd2, 32'd5, 32'd7, 32'd1,
                                            32'd0, 32'd5, 32'hFFFF_FFFE, 32'd7};
  // requirement per entry: R4 add/sub/and/or/slt, R8 reg 0, R7 fallthrough, R4 negative, R5 neg offset
  localparam int WR_REQ [N_WR] = '{4, 4, 4, 4, 4, 8, 7, 4, 5};

  mcp_core i_mcp_core (
    .clk(clk), .rst(rst), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe)
  );

  always #5 clk = ~clk;

  assign memRdata = mem[memAddr[7:2]];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:2]] <= memWdata;
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && memWe && logEn && nWr < 16) begin
      logCyc[nWr] = cyc;
      logAdr[nWr] = memAddr;
      logDat[nWr] = memWdata;
      nWr++;
    end
  end

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCycle(int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic loadProgram();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = encI(6'h23, 0, 1, 16'h0080);   // r1 = 5
    mem[1]  = encI(6'h23, 0, 2, 16'h0084);   // r2 = 7
    mem[2]  = encR(1, 2, 3, 6'h20);          // r3 = 12
    mem[3]  = encR(2, 1, 4, 6'h22);          // r4 = 2
    mem[4]  = encR(1, 2, 5, 6'h24);          // r5 = 5
    mem[5]  = encR(1, 2, 6, 6'h25);          // r6 = 7
    mem[6]  = encR(1, 2, 7, 6'h2A);          // r7 = 1
    mem[7]  = encR(1, 2, 0, 6'h20);          // write to r0
    mem[8]  = encI(6'h2B, 0, 3, 16'h0090);
    mem[9]  = encI(6'h2B, 0, 4, 16'h0094);
    mem[10] = encI(6'h2B, 0, 5, 16'h0098);
    mem[11] = encI(6'h2B, 0, 6, 16'h009c);
    mem[12] = encI(6'h2B, 0, 7, 16'h00a0);
    mem[13] = encI(6'h2B, 0, 0, 16'h00a4);
    mem[14] = encI(6'h04, 1, 2, 16'h0005);   // not taken
    mem[15] = encI(6'h2B, 0, 1, 16'h00a8);
    mem[16] = encI(6'h04, 1, 1, 16'h0002);   // taken to word 19
    mem[17] = encI(6'h2B, 0, 2, 16'h00ac);
    mem[18] = encI(6'h2B, 0, 2, 16'h00ac);
    mem[19] = encR(1, 2, 8, 6'h22);          // r8 = -2
    mem[20] = encI(6'h2B, 0, 8, 16'h00b0);
    mem[21] = encI(6'h23, 0, 10, 16'h0088);  // r10 = 0xC0
    mem[22] = encI(6'h23, 10, 9, 16'hFFC4);  // r9 = mem[0x84]
    mem[23] = encI(6'h2B, 0, 9, 16'h00b4);
    mem[24] = encI(6'h04, 0, 0, 16'hFFFF);   // branch to itself
    mem[32] = 32'd5;
    mem[33] = 32'd7;
    mem[34] = 32'h0000_00C0;
    mem[41] = 32'hDEAD_BEEF;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    loadProgram();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", memAddr, 32'h0);
    chk("R1 we in reset", {31'h0, memWe}, 32'h0);
    rst = 1'b0;
    chk("R1 addr first cycle", memAddr, 32'h0);
    chk("R1 we first cycle", {31'h0, memWe}, 32'h0);
    waitCycle(3);
    chk("R5 load address cycle 4 of load", memAddr, 32'h80);
    waitCycle(5);
    chk("R3 R2 second fetch after 5-cycle load", memAddr, 32'h4);
    waitCycle(10);
    chk("R3 R2 third fetch", memAddr, 32'h8);
    waitCycle(14);
    chk("R3 fetch after 4-cycle register op", memAddr, 32'hC);
    waitCycle(120);

    for (int i = 0; i < N_WR; i++) begin
      if (i < nWr) begin
        nChk++;
        if (logCyc[i] !== WR_CYC[i] || logAdr[i] !== WR_ADR[i] || logDat[i] !== WR_DAT[i]) begin
          nFail++;
          $display("FAIL R%0d/R3/R6 store %0d: actual c%0d %h %h expected c%0d %h %h",
                   WR_REQ[i], i, logCyc[i], logAdr[i], logDat[i],
                   WR_CYC[i], WR_ADR[i], WR_DAT[i]);
        end
      end else begin
        chk("R6 store missing", 32'(nWr), 32'(N_WR));
      end
    end
    chk("R7 taken branch skipped stores", 32'(nWr), 32'(N_WR));
    chk("R6 memory word from store", mem[42], 32'd5);
    chk("R8 r0 store replaced old word", mem[41], 32'h0);
    chk("R9 data word at 0x84 intact", mem[33], 32'd7);

    logEn = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run addr", memAddr, 32'h0);
    chk("R1 reset mid-run we", {31'h0, memWe}, 32'h0);
    rst = 1'b0;
    chk("R1 first cycle after mid-run reset", memAddr, 32'h0);
    waitCycle(5);
    chk("R2 refetch word 1 after reset", memAddr, 32'h4);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule